// File: doc/BRIEF.md
# Debug Control Register with Clock-Domain Crossing

This block holds a debug control word that a test-access controller reads and writes through a 32-bit shift path clocked by the test clock. Three fields have meaning. Bit 14 chooses where the debug exception vector lies. Bit 12 is a write-one bit that requests a debug interrupt and reads back as pending. Bit 3 reports whether the processor is in debug mode. Every other bit reads as zero.

The processor side runs on its own clock, and the two clocks are unrelated. Each direction of transfer crosses the clock boundary through a toggle handshake that is synchronized by a chain of flops. The vector select is sent as bundled data and held stable while its toggle crosses. The test-clock side shows the new select value only after the processor side has acknowledged it. A debug request is launched only once any select change in flight has landed. This ordering guarantees that the exception uses the select value written before or together with the request. A boot-indication input sets the reset values of the select and request bits.

The processor side returns one acknowledge toggle per request in two cases: when it enters debug mode and clears the request, and when it discards a request that arrives while it is already in debug mode. A level taken from the test-clock domain asks the processor to restart a stopped clock while a request is pending.

Top module: `dbg_ctl_cdc`

## Requirements
- R1: At reset, bit 14 and bit 12 of the read word, `cpu_trap_sel` and `cpu_dint_req` all equal `boot_dbg`, and bit 3 reads 0.
- R2: Every bit of the read word other than 14, 12 and 3 reads 0, whatever value was last written to it.
- R3: After a write changes bit 14, the read word shows the old value on the next access. When the read word first shows the new value, `cpu_trap_sel` already holds that new value.
- R4: `cpu_vec_addr` is 32'hBFC00480 when `cpu_trap_sel` is 0 and 32'hFF200200 when it is 1.
- R5: Writing 1 to bit 12 while the processor is not in debug mode raises `cpu_dint_req`, and bit 12 then reads 1 while the request is pending. Writing 0 to bit 12 has no effect.
- R6: A request written while `cpu_dbg_mode` is 1 is discarded. This holds whether the test-clock side already sees debug mode or the processor side finds it on arrival. In both cases `cpu_dint_req` stays 0 and bit 12 returns to 0.
- R7: A pulse on `cpu_dbg_entry` clears `cpu_dint_req` on the next processor clock, and bit 12 then reads 0.
- R8: `cpu_wake_req` is 1 while bit 12 is pending and 0 otherwise, and it is driven from the test-clock domain.
- R9: Bit 3 follows `cpu_dbg_mode` after synchronization into the test-clock domain.
- R10: When bit 14 and bit 12 are written in the same update, `cpu_dint_req` rises only after `cpu_trap_sel` has taken the new bit 14 value.
- R11: Writing 1 to bit 12 again while a request is pending creates no second request. After the single request is cleared, `cpu_dint_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst_n | input | 1 | Active-low asynchronous reset, test-clock domain |
| tdi | input | 1 | Serial data into the shift path, LSB first |
| cap_en | input | 1 | Load the read word into the shift path |
| shf_en | input | 1 | Shift the path one bit toward `tdo` |
| upd_en | input | 1 | Apply the shifted word as a write |
| tdo | output | 1 | Serial data out of the shift path |
| cpu_clk | input | 1 | Processor clock |
| cpu_rst_n | input | 1 | Active-low asynchronous reset, processor domain |
| boot_dbg | input | 1 | Boot indication that selects the reset values of bits 14 and 12 |
| cpu_dbg_mode | input | 1 | Processor is in debug mode |
| cpu_dbg_entry | input | 1 | One-cycle pulse when the processor enters debug mode |
| cpu_dint_req | output | 1 | Debug interrupt request to the processor |
| cpu_trap_sel | output | 1 | Vector select as seen in the processor domain |
| cpu_vec_addr | output | 32 | Debug exception vector address chosen by `cpu_trap_sel` |
| cpu_wake_req | output | 1 | Clock-restart request while a debug request is pending |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a select change and a debug request written in one update. The bench provokes this by shifting in a word with both bits set. It then judges the result by requiring that, at the first processor cycle where `cpu_dint_req` is high, `cpu_trap_sel` already shows the new value. The second pair is the arrival of a request at the processor side and that side's own entry into debug mode. The bench provokes this by raising `cpu_dbg_mode` just after the update edge, before the request toggle can cross. It then requires that the request never appears and that bit 12 reads back as cleared.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;

  localparam int WORD_W   = 32;
  localparam int TRAP_POS = 14;
  localparam int BRK_POS  = 12;
  localparam int DM_POS   = 3;

  localparam logic [WORD_W-1:0] VEC_NORMAL = 32'hBFC0_0480;
  localparam logic [WORD_W-1:0] VEC_DSEG   = 32'hFF20_0200;

  // Vector address selected by the trap bit.
  function automatic logic [WORD_W-1:0] vec_addr(input logic trap);
    return trap ? VEC_DSEG : VEC_NORMAL;
  endfunction

  // Read word: only the three owned bits can be nonzero.
  function automatic logic [WORD_W-1:0] pack_status(input logic trap,
                                                    input logic brk,
                                                    input logic dm);
    logic [WORD_W-1:0] w;
    w           = '0;
    w[TRAP_POS] = trap;
    w[BRK_POS]  = brk;
    w[DM_POS]   = dm;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] owned_mask();
    return pack_status(1'b1, 1'b1, 1'b1);
  endfunction

  // A toggle handshake event is a difference between new and remembered level.
  function automatic logic tgl_event(input logic now_lvl, input logic prev_lvl);
    return now_lvl ^ prev_lvl;
  endfunction

endpackage

// File: rtl/dbgctl_sync.sv
module dbgctl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {STAGES{RST_VAL}};
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/dbgctl_jtag_side.sv
module dbgctl_jtag_side
  import dbgctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              tck,
  input  logic              tck_rst_n,
  input  logic              boot_dbg,
  input  logic              tdi,
  input  logic              cap_en,
  input  logic              shf_en,
  input  logic              upd_en,
  output logic              tdo,
  input  logic              dbg_mode_async,
  input  logic              trap_ack_async,
  input  logic              brk_ack_async,
  output logic              trap_req_tgl,
  output logic              trap_tx,
  output logic              brk_req_tgl,
  output logic              brk_pend,
  output logic              trap_shown,
  output logic              trap_idle,
  output logic              trap_ack_evt,
  output logic              brk_launch_evt,
  output logic              brk_wr1_evt,
  output logic [WORD_W-1:0] shift_q
);
  logic dm_s, trap_ack_s, brk_ack_s;
  logic trap_ack_prev, brk_ack_prev;
  logic trap_want, trap_busy, brk_sent;
  logic brk_ack_evt;

  dbgctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dm_sync (
    .clk(tck), .rst_n(tck_rst_n), .din(dbg_mode_async), .dout(dm_s));
  dbgctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tack_sync (
    .clk(tck), .rst_n(tck_rst_n), .din(trap_ack_async), .dout(trap_ack_s));
  dbgctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_back_sync (
    .clk(tck), .rst_n(tck_rst_n), .din(brk_ack_async), .dout(brk_ack_s));

  // Shift path: capture the status word, shift LSB first, update applies.
  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n)  shift_q <= '0;
    else if (cap_en) shift_q <= pack_status(trap_shown, brk_pend, dm_s);
    else if (shf_en) shift_q <= {tdi, shift_q[WORD_W-1:1]};
  end
  assign tdo = shift_q[0];

  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n) begin
      trap_ack_prev <= 1'b0;
      brk_ack_prev  <= 1'b0;
    end else begin
      trap_ack_prev <= trap_ack_s;
      brk_ack_prev  <= brk_ack_s;
    end
  end
  assign trap_ack_evt = tgl_event(trap_ack_s, trap_ack_prev);
  assign brk_ack_evt  = tgl_event(brk_ack_s, brk_ack_prev);

  // Vector select: requested value, value in flight, value confirmed.
  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n)  trap_want <= boot_dbg;
    else if (upd_en) trap_want <= shift_q[TRAP_POS];
  end

  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n) begin
      trap_shown   <= boot_dbg;
      trap_tx      <= boot_dbg;
      trap_busy    <= 1'b0;
      trap_req_tgl <= 1'b0;
    end else if (trap_ack_evt) begin
      trap_shown <= trap_tx;
      trap_busy  <= 1'b0;
    end else if (!trap_busy && (trap_want != trap_shown)) begin
      trap_tx      <= trap_want;
      trap_req_tgl <= ~trap_req_tgl;
      trap_busy    <= 1'b1;
    end
  end
  assign trap_idle = !trap_busy && (trap_want == trap_shown);

  // Debug request: pending flag set by write-one, launched after the select settles.
  assign brk_wr1_evt    = upd_en && shift_q[BRK_POS] && !brk_pend && !dm_s;
  assign brk_launch_evt = brk_pend && !brk_sent && trap_idle && !brk_ack_evt;

  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n) begin
      brk_pend    <= boot_dbg;
      brk_sent    <= boot_dbg;
      brk_req_tgl <= 1'b0;
    end else if (brk_ack_evt) begin
      brk_pend <= 1'b0;
      brk_sent <= 1'b0;
    end else if (brk_wr1_evt) begin
      brk_pend <= 1'b1;
    end else if (brk_launch_evt) begin
      brk_sent    <= 1'b1;
      brk_req_tgl <= ~brk_req_tgl;
    end
  end
endmodule

// File: rtl/dbgctl_cpu_side.sv
module dbgctl_cpu_side
  import dbgctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_dbg,
  input  logic trap_req_async,
  input  logic trap_tx_async,
  input  logic brk_req_async,
  input  logic dbg_mode,
  input  logic dbg_entry,
  output logic trap_sel,
  output logic dint_req,
  output logic trap_ack_tgl,
  output logic brk_ack_tgl,
  output logic trap_arrive_evt,
  output logic brk_arrive_evt
);
  logic trap_req_s, brk_req_s;
  logic trap_req_prev, brk_req_prev;

  dbgctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_treq_sync (
    .clk(clk), .rst_n(rst_n), .din(trap_req_async), .dout(trap_req_s));
  dbgctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_breq_sync (
    .clk(clk), .rst_n(rst_n), .din(brk_req_async), .dout(brk_req_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req_prev <= 1'b0;
      brk_req_prev  <= 1'b0;
    end else begin
      trap_req_prev <= trap_req_s;
      brk_req_prev  <= brk_req_s;
    end
  end
  assign trap_arrive_evt = tgl_event(trap_req_s, trap_req_prev);
  assign brk_arrive_evt  = tgl_event(brk_req_s, brk_req_prev);

  // Select bit is held stable by the sender while its toggle crosses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_sel     <= boot_dbg;
      trap_ack_tgl <= 1'b0;
    end else if (trap_arrive_evt) begin
      trap_sel     <= trap_tx_async;
      trap_ack_tgl <= ~trap_ack_tgl;
    end
  end

  // Arrival in debug mode is acknowledged at once; otherwise held until entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dint_req    <= boot_dbg;
      brk_ack_tgl <= 1'b0;
    end else if (brk_arrive_evt) begin
      if (dbg_mode || dbg_entry) brk_ack_tgl <= ~brk_ack_tgl;
      else                       dint_req    <= 1'b1;
    end else if (dbg_entry && dint_req) begin
      dint_req    <= 1'b0;
      brk_ack_tgl <= ~brk_ack_tgl;
    end
  end
endmodule

// File: rtl/dbg_ctl_cdc.sv
module dbg_ctl_cdc
  import dbgctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              tck,
  input  logic              tck_rst_n,
  input  logic              tdi,
  input  logic              cap_en,
  input  logic              shf_en,
  input  logic              upd_en,
  output logic              tdo,
  input  logic              cpu_clk,
  input  logic              cpu_rst_n,
  input  logic              boot_dbg,
  input  logic              cpu_dbg_mode,
  input  logic              cpu_dbg_entry,
  output logic              cpu_dint_req,
  output logic              cpu_trap_sel,
  output logic [WORD_W-1:0] cpu_vec_addr,
  output logic              cpu_wake_req
);
  logic              trap_req_tgl, trap_tx, brk_req_tgl;
  logic              trap_ack_tgl, brk_ack_tgl;
  logic              brk_pend, trap_shown, trap_idle;
  logic              trap_ack_evt, brk_launch_evt, brk_wr1_evt;
  logic              trap_arrive_evt, brk_arrive_evt;
  logic [WORD_W-1:0] shift_q;

  dbgctl_jtag_side #(.SYNC_STAGES(SYNC_STAGES)) u_jtag (
    .tck(tck), .tck_rst_n(tck_rst_n), .boot_dbg(boot_dbg),
    .tdi(tdi), .cap_en(cap_en), .shf_en(shf_en), .upd_en(upd_en), .tdo(tdo),
    .dbg_mode_async(cpu_dbg_mode), .trap_ack_async(trap_ack_tgl),
    .brk_ack_async(brk_ack_tgl), .trap_req_tgl(trap_req_tgl), .trap_tx(trap_tx),
    .brk_req_tgl(brk_req_tgl), .brk_pend(brk_pend), .trap_shown(trap_shown),
    .trap_idle(trap_idle), .trap_ack_evt(trap_ack_evt),
    .brk_launch_evt(brk_launch_evt), .brk_wr1_evt(brk_wr1_evt), .shift_q(shift_q));

  dbgctl_cpu_side #(.SYNC_STAGES(SYNC_STAGES)) u_cpu (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .boot_dbg(boot_dbg),
    .trap_req_async(trap_req_tgl), .trap_tx_async(trap_tx),
    .brk_req_async(brk_req_tgl), .dbg_mode(cpu_dbg_mode), .dbg_entry(cpu_dbg_entry),
    .trap_sel(cpu_trap_sel), .dint_req(cpu_dint_req),
    .trap_ack_tgl(trap_ack_tgl), .brk_ack_tgl(brk_ack_tgl),
    .trap_arrive_evt(trap_arrive_evt), .brk_arrive_evt(brk_arrive_evt));

  assign cpu_vec_addr = vec_addr(cpu_trap_sel);
  assign cpu_wake_req = brk_pend;
endmodule

// File: rtl/dbg_ctl_cdc_chk.sv
module dbg_ctl_cdc_chk
  import dbgctl_pkg::*;
(
  input logic              tck,
  input logic              tck_rst_n,
  input logic              cpu_clk,
  input logic              cpu_rst_n,
  input logic              cap_en,
  input logic              upd_en,
  input logic [WORD_W-1:0] shift_q,
  input logic              trap_shown,
  input logic              trap_ack_evt,
  input logic              brk_pend,
  input logic              brk_launch_evt,
  input logic              cpu_trap_sel,
  input logic              trap_arrive_evt,
  input logic              cpu_dint_req,
  input logic              cpu_dbg_mode,
  input logic              cpu_dbg_entry,
  input logic              brk_arrive_evt
);
  AST_RSVD_ZERO: assert property (@(posedge tck) disable iff (!tck_rst_n)
    cap_en |=> ((shift_q & ~owned_mask()) == '0)); // R2

  AST_SHOWN_AFTER_ACK: assert property (@(posedge tck) disable iff (!tck_rst_n)
    !$stable(trap_shown) |-> $past(trap_ack_evt)); // R3

  AST_PEND_FROM_UPDATE: assert property (@(posedge tck) disable iff (!tck_rst_n)
    $rose(brk_pend) |-> $past(upd_en)); // R5

  AST_LAUNCH_NEEDS_PEND: assert property (@(posedge tck) disable iff (!tck_rst_n)
    brk_launch_evt |=> brk_pend); // R10

  AST_SEL_ON_ARRIVAL: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    !$stable(cpu_trap_sel) |-> $past(trap_arrive_evt)); // R3

  AST_DINT_CAUSE: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    $rose(cpu_dint_req) |-> $past(brk_arrive_evt && !cpu_dbg_mode && !cpu_dbg_entry)); // R6

  AST_ENTRY_CLEARS: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    cpu_dbg_entry |=> !cpu_dint_req); // R7

  AST_NO_DUP_ARRIVAL: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    brk_arrive_evt |-> !cpu_dint_req); // R11
endmodule

bind dbg_ctl_cdc dbg_ctl_cdc_chk u_chk (
  .tck(tck), .tck_rst_n(tck_rst_n), .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
  .cap_en(cap_en), .upd_en(upd_en), .shift_q(shift_q),
  .trap_shown(trap_shown), .trap_ack_evt(trap_ack_evt),
  .brk_pend(brk_pend), .brk_launch_evt(brk_launch_evt),
  .cpu_trap_sel(cpu_trap_sel), .trap_arrive_evt(trap_arrive_evt),
  .cpu_dint_req(cpu_dint_req), .cpu_dbg_mode(cpu_dbg_mode),
  .cpu_dbg_entry(cpu_dbg_entry), .brk_arrive_evt(brk_arrive_evt));

// File: tb/dbg_ctl_cdc_test.sv
module dbg_ctl_cdc_test;
  localparam time CLK_PERIOD = 10ns;
  localparam time TCK_PERIOD = 37ns;
  localparam logic [31:0] V0 = 32'hBFC0_0480;
  localparam logic [31:0] V1 = 32'hFF20_0200;

  logic tck = 0, cpu_clk = 0;
  logic tck_rst_n = 0, cpu_rst_n = 0;
  logic tdi = 0, cap_en = 0, shf_en = 0, upd_en = 0, tdo;
  logic boot_dbg = 0, cpu_dbg_mode = 0, cpu_dbg_entry = 0;
  logic cpu_dint_req, cpu_trap_sel, cpu_wake_req;
  logic [31:0] cpu_vec_addr;
  int tests = 0, fails = 0;
  logic trap_cur = 0;

  always #(TCK_PERIOD/2) tck = ~tck;
  always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;

  dbg_ctl_cdc uut (
    .tck(tck), .tck_rst_n(tck_rst_n), .tdi(tdi), .cap_en(cap_en),
    .shf_en(shf_en), .upd_en(upd_en), .tdo(tdo), .cpu_clk(cpu_clk),
    .cpu_rst_n(cpu_rst_n), .boot_dbg(boot_dbg), .cpu_dbg_mode(cpu_dbg_mode),
    .cpu_dbg_entry(cpu_dbg_entry), .cpu_dint_req(cpu_dint_req),
    .cpu_trap_sel(cpu_trap_sel), .cpu_vec_addr(cpu_vec_addr),
    .cpu_wake_req(cpu_wake_req));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic jtag_rw(input logic [31:0] wd, output logic [31:0] rd);
    @(negedge tck) cap_en = 1;
    @(negedge tck) cap_en = 0; shf_en = 1;
    for (int i = 0; i < 32; i++) begin
      tdi = wd[i];
      rd[i] = tdo;
      @(negedge tck);
    end
    shf_en = 0; upd_en = 1;
    @(negedge tck) upd_en = 0;
  endtask

  function automatic logic [31:0] wr_word(input logic trap, input logic brk);
    logic [31:0] w;
    w = 32'h0;
    w[14] = trap;
    w[12] = brk;
    return w;
  endfunction

  task automatic do_reset(input logic boot);
    tck_rst_n = 0; cpu_rst_n = 0; boot_dbg = boot;
    cpu_dbg_mode = 0; cpu_dbg_entry = 0; trap_cur = boot;
    repeat (3) @(negedge tck);
    tck_rst_n = 1;
    @(negedge cpu_clk) cpu_rst_n = 1;
    @(negedge tck);
  endtask

  task automatic entry_pulse();
    @(negedge cpu_clk) cpu_dbg_entry = 1; cpu_dbg_mode = 1;
    @(negedge cpu_clk) cpu_dbg_entry = 0;
  endtask

  task automatic test_reset(input logic boot);
    logic [31:0] rd;
    do_reset(boot);
    chk(cpu_trap_sel == boot, "R1 trap_sel", cpu_trap_sel, boot);
    chk(cpu_dint_req == boot, "R1 dint_req", cpu_dint_req, boot);
    chk(cpu_vec_addr == (boot ? V1 : V0), "R4 vec at reset", cpu_vec_addr, boot ? V1 : V0);
    chk(cpu_wake_req == boot, "R8 wake at reset", cpu_wake_req, boot);
    jtag_rw(wr_word(boot, 1'b0), rd);
    chk(rd == wr_word(boot, boot), "R1 read word", rd, wr_word(boot, boot));
  endtask

  task automatic test_reserved();
    logic [31:0] rd;
    jtag_rw(32'hFFFF_FFFF & ~wr_word(1'b1, 1'b1), rd);
    jtag_rw(wr_word(trap_cur, 1'b0), rd);
    chk(rd == 32'h0, "R2 reserved bits", rd, 32'h0);
    repeat (20) @(negedge cpu_clk);
    chk(cpu_dint_req == 0, "R5 write0 no effect", cpu_dint_req, 0);
  endtask

  task automatic test_trap(input logic v);
    logic [31:0] rd;
    bit seen = 0;
    jtag_rw(wr_word(v, 1'b0), rd);
    trap_cur = v;
    jtag_rw(wr_word(v, 1'b0), rd);
    chk(rd[14] == !v, "R3 old value first", rd, wr_word(!v, 1'b0));
    for (int i = 0; i < 20 && !seen; i++) begin
      jtag_rw(wr_word(v, 1'b0), rd);
      if (rd[14] == v) begin
        seen = 1;
        chk(cpu_trap_sel == v, "R3 cpu has value", cpu_trap_sel, v);
      end
    end
    chk(seen, "R3 readback arrives", rd, wr_word(v, 1'b0));
    chk(cpu_vec_addr == (v ? V1 : V0), "R4 vec", cpu_vec_addr, v ? V1 : V0);
  endtask

  task automatic test_brk();
    logic [31:0] rd;
    bit up = 0;
    jtag_rw(wr_word(trap_cur, 1'b1), rd);
    for (int i = 0; i < 100 && !up; i++) begin
      @(negedge cpu_clk);
      if (cpu_dint_req) up = 1;
    end
    chk(up, "R5 dint raised", cpu_dint_req, 1);
    chk(cpu_wake_req == 1, "R8 wake while pending", cpu_wake_req, 1);
    jtag_rw(wr_word(trap_cur, 1'b1), rd);
    chk(rd[12] == 1, "R5 pending reads 1", rd, wr_word(trap_cur, 1'b1));
    entry_pulse();
    chk(cpu_dint_req == 0, "R7 entry clears", cpu_dint_req, 0);
    repeat (30) @(negedge cpu_clk);
    jtag_rw(wr_word(trap_cur, 1'b0), rd);
    chk(rd[12] == 0, "R7 bit12 cleared", rd, wr_word(trap_cur, 1'b0));
    chk(rd[3] == 1, "R9 dm bit set", rd, 32'h8);
    chk(cpu_wake_req == 0, "R8 wake drops", cpu_wake_req, 0);
    up = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge cpu_clk);
      if (cpu_dint_req) up = 1;
    end
    chk(!up, "R11 no duplicate request", up, 0);
  endtask

  task automatic test_drop_tck();
    logic [31:0] rd;
    bit up = 0;
    jtag_rw(wr_word(trap_cur, 1'b1), rd);
    for (int i = 0; i < 60; i++) begin
      @(negedge cpu_clk);
      if (cpu_dint_req) up = 1;
    end
    chk(!up, "R6 dropped (sync dm)", up, 0);
    jtag_rw(wr_word(trap_cur, 1'b0), rd);
    chk(rd[12] == 0, "R6 bit12 zero", rd, wr_word(trap_cur, 1'b0));
    cpu_dbg_mode = 0;
    repeat (4) @(negedge tck);
    jtag_rw(wr_word(trap_cur, 1'b0), rd);
    chk(rd[3] == 0, "R9 dm bit clear", rd, 32'h0);
  endtask

  task automatic test_drop_cpu();
    logic [31:0] rd;
    bit up = 0;
    jtag_rw(wr_word(trap_cur, 1'b1), rd);
    cpu_dbg_mode = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge cpu_clk);
      if (cpu_dint_req) up = 1;
    end
    chk(!up, "R6 dropped on arrival", up, 0);
    jtag_rw(wr_word(trap_cur, 1'b0), rd);
    chk(rd[12] == 0, "R6 bit12 after drop", rd, wr_word(trap_cur, 1'b0));
    cpu_dbg_mode = 0;
    repeat (4) @(negedge tck);
  endtask

  task automatic test_same_update();
    logic [31:0] rd;
    bit up = 0;
    logic nv;
    nv = !trap_cur;
    jtag_rw(wr_word(nv, 1'b1), rd);
    trap_cur = nv;
    for (int i = 0; i < 200 && !up; i++) begin
      @(negedge cpu_clk);
      if (cpu_dint_req) begin
        up = 1;
        chk(cpu_trap_sel == nv, "R10 select before request", cpu_trap_sel, nv);
      end
    end
    chk(up, "R10 request raised", up, 1);
    entry_pulse();
    cpu_dbg_mode = 0;
    repeat (30) @(negedge cpu_clk);
  endtask

  task automatic test_boot_clear();
    logic [31:0] rd;
    entry_pulse();
    chk(cpu_dint_req == 0, "R7 boot request cleared", cpu_dint_req, 0);
    repeat (30) @(negedge cpu_clk);
    jtag_rw(wr_word(trap_cur, 1'b0), rd);
    chk(rd[12] == 0, "R7 boot bit12 cleared", rd, 32'h0);
    cpu_dbg_mode = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    test_reset(1'b0);
    test_reserved();
    test_trap(1'b1);
    test_trap(1'b0);
    test_brk();
    test_drop_tck();
    test_drop_cpu();
    test_same_update();
    test_reset(1'b1);
    test_boot_clear();
    summary();
    $finish;
  end
endmodule